// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the register front end of an I/O interrupt routing controller. Software sees only two locations: an 8-bit select register and a 32-bit data window. The select value decides what the window reaches. It can reach a read-only version word, a 4-bit identification field, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin. The block stores the routing table itself and drives every entry's fields straight out to the interrupt servicing logic.

The servicing logic gives back two things. It sets and clears each entry's remote-request status bit through pulse inputs, and it presents its per-pin pending-request flags. The block raises a one-cycle event carrying an entry index when a software write changes that entry's mask bit. It raises the same event when a software write leaves a level-triggered entry with a request pending, so the servicing logic can re-evaluate that pin. The bus side is a plain synchronous port: one enable, one write strobe, byte address, and a read result registered one cycle later.

Top module: `irq_route_regs`

## Requirements
- R1: A write to address 0x00 loads bits 7:0 of the write data into the select register. A read of address 0x00 returns the select value zero-extended to 32 bits.
- R2: Addresses other than 0x00 (select) and 0x10 (window) read as zero, and writes to them change nothing.
- R3: With select 0x00 the window reads {8'h00, PINS-1 as 8 bits, 8'h00, VERSION}. Writes there are ignored.
- R4: With select 0x01 a window write stores write data bits 27:24 as the ID. With select 0x01 or 0x02 the window reads the ID in bits 27:24 and zero elsewhere. A write with select 0x02 is ignored.
- R5: For select 0x10 and above, the entry index is (select-0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. A write to one half leaves the other half and all other entries unchanged.
- R6: An index at or beyond PINS reads as 32'hFFFF_FFFF, and so do selects 0x03 to 0x0F. Writes to them are discarded.
- R7: A window write to the low half of an entry forces its remote-request bit (bit 14) to 0, whatever the data says. A high-half write leaves that bit unchanged.
- R8: After reset, the select register and the ID are 0. Every entry holds 0 except its mask bit (bit 16), which is 1.
- R9: The entry layout is vector 7:0, delivery mode 10:8, destination mode 11, remote request 14, trigger mode 15 (1 = level), mask 16, destination 63:56. The field output ports show these bits of each stored entry.
- R10: A pulse on rirr_set[i] sets entry i's remote-request bit, and a pulse on rirr_clr[i] clears it. When both pulse together, the bit ends cleared.
- R11: One cycle after a window write to a valid entry, evt_valid is high for exactly one cycle with evt_index set to that entry. This happens only if the write changes the mask bit, or if the entry's trigger mode after the write is level while pend_in of that entry is high. No other write raises evt_valid.
- R12: bus_rdata takes the addressed value at the clock edge where a read is requested (bus_en high, bus_we low). It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pend_in | input | PINS | Pending-request flag per pin from the servicing logic |
| rirr_set | input | PINS | Pulse: set remote-request bit of the entry |
| rirr_clr | input | PINS | Pulse: clear remote-request bit of the entry |
| ent_vector | output | PINS*8 | Vector field of each entry |
| ent_dlv | output | PINS*3 | Delivery mode field of each entry |
| ent_dmode | output | PINS | Destination mode bit of each entry |
| ent_rirr | output | PINS | Remote-request bit of each entry |
| ent_trig | output | PINS | Trigger mode bit of each entry |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_dest | output | PINS*8 | Destination field of each entry |
| evt_valid | output | 1 | One-cycle re-evaluation event |
| evt_index | output | $clog2(PINS) | Entry index of the event |

## Verification
A corrupted table word shows up on the field output ports in the same cycle it is stored. It also shows on bus_rdata one cycle after any read of that half. A half-write that spills into the neighbouring half, or into the wrong entry, is therefore caught by the next readback of either half or of a nearby index. A wrong select decode moves every later window access to the wrong target, so the first version, ID or entry read after it returns a value off by whole fields. A stale or wrongly computed event shows as a missing or extra evt_valid in the cycle right after the write, never later.

// File: rtl/irq_route_pkg.sv
// Shared definitions for the interrupt routing register window.
// Assumes 64-bit routing entries with the fixed field layout below.
package irq_route_pkg;

    typedef enum logic [2:0] {
        SK_VER,
        SK_ID,
        SK_ARB,
        SK_ENT,
        SK_BAD
    } sel_kind_t;

    localparam int ENT_W     = 64;
    localparam int F_VEC_LO  = 0;
    localparam int F_DLV_LO  = 8;
    localparam int F_DMODE   = 11;
    localparam int F_RIRR    = 14;
    localparam int F_TRIG    = 15;
    localparam int F_MASK    = 16;
    localparam int F_DEST_LO = 56;

    localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;

    localparam logic [7:0] SEL_VER  = 8'h00;
    localparam logic [7:0] SEL_ID   = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_BASE = 8'h10;

endpackage

// File: rtl/irq_route_decode.sv
// Select decoder: turns the 8-bit select value into a target kind, an
// entry index and a half flag. Assumes PINS <= 120 so every index fits.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int PINS = 24,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic [7:0]      sel,
    output sel_kind_t       kind,
    output logic [IDXW-1:0] idx,
    output logic            hi_half
);
    logic [7:0] off;
    logic [6:0] raw;

    // Offset of the select above the table base, halved to an entry number.
    always_comb begin
        off = sel - SEL_BASE;
        raw = off[7:1];
    end

    // Classify the select value.
    always_comb begin
        hi_half = sel[0];
        idx     = raw[IDXW-1:0];
        if (sel == SEL_VER)
            kind = SK_VER;
        else if (sel == SEL_ID)
            kind = SK_ID;
        else if (sel == SEL_ARB)
            kind = SK_ARB;
        else if (sel < SEL_BASE)
            kind = SK_BAD;
        else if ({25'd0, raw} < PINS)
            kind = SK_ENT;
        else
            kind = SK_BAD;
    end

endmodule

// File: rtl/irq_route_entry.sv
// One routing entry: 64-bit storage written in two 32-bit halves, plus a
// remote-request status bit set and cleared by the servicing logic.
// Assumes wr_lo and wr_hi are never high together.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             rirr_set,
    input  logic             rirr_clr,
    output logic [ENT_W-1:0] ent_q
);

    // Entry storage update: halves from the bus, status bit from servicing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= ENT_RST;
        end else begin
            if (wr_lo)
                ent_q[31:0] <= {wdata[31:F_RIRR+1], 1'b0, wdata[F_RIRR-1:0]};
            if (wr_hi)
                ent_q[63:32] <= wdata;
            if (!wr_lo) begin
                if (rirr_clr)
                    ent_q[F_RIRR] <= 1'b0;
                else if (rirr_set)
                    ent_q[F_RIRR] <= 1'b1;
            end
        end
    end

    AST_LO_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !ent_q[F_RIRR]); // R7

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> ({ent_q[31:F_RIRR+1], ent_q[F_RIRR-1:0]} ==
                               $past({ent_q[31:F_RIRR+1], ent_q[F_RIRR-1:0]}))); // R5

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rirr_clr |=> !ent_q[F_RIRR]); // R10

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set && !rirr_clr && !wr_lo) |=> ent_q[F_RIRR]); // R10

endmodule

// File: rtl/irq_route_rdmux.sv
// Window read multiplexer: builds the 32-bit word the window shows for the
// current select. Purely combinational; the caller registers it.
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int         PINS    = 24,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int IDXW = $clog2(PINS)
) (
    input  sel_kind_t        kind,
    input  logic [IDXW-1:0]  idx,
    input  logic             hi_half,
    input  logic [3:0]       id_q,
    input  logic [ENT_W-1:0] tbl [PINS],
    output logic [31:0]      win_word
);
    localparam logic [7:0] PMAX = 8'(PINS - 1);

    logic [ENT_W-1:0] sel_ent;

    // Fetch the addressed entry.
    always_comb sel_ent = tbl[idx];

    // Choose the window contents by target kind.
    always_comb begin
        unique case (kind)
            SK_VER:        win_word = {8'h00, PMAX, 8'h00, VERSION};
            SK_ID, SK_ARB: win_word = {4'h0, id_q, 24'h0};
            SK_ENT:        win_word = hi_half ? sel_ent[63:32] : sel_ent[31:0];
            default:       win_word = 32'hFFFF_FFFF;
        endcase
    end

endmodule

// File: rtl/irq_route_regs.sv
// Interrupt routing register window, top level. It holds the select register,
// the ID field and a PINS-entry routing table behind a select/window pair.
// It exports every entry's fields and flags entries that need re-evaluation.
// Assumes a single-cycle synchronous bus port and PINS between 2 and 120.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         PINS     = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic [7:0] SEL_ADDR = 8'h00,
    parameter logic [7:0] WIN_ADDR = 8'h10,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pend_in,
    input  logic [PINS-1:0]   rirr_set,
    input  logic [PINS-1:0]   rirr_clr,
    output logic [PINS*8-1:0] ent_vector,
    output logic [PINS*3-1:0] ent_dlv,
    output logic [PINS-1:0]   ent_dmode,
    output logic [PINS-1:0]   ent_rirr,
    output logic [PINS-1:0]   ent_trig,
    output logic [PINS-1:0]   ent_mask,
    output logic [PINS*8-1:0] ent_dest,
    output logic              evt_valid,
    output logic [IDXW-1:0]   evt_index
);
    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    sel_kind_t        kind;
    logic [IDXW-1:0]  idx;
    logic             hi_half;
    logic [ENT_W-1:0] tbl [PINS];
    logic [31:0]      win_word;
    logic             sel_wr, win_wr, ent_wr, rd_req;
    logic [ENT_W-1:0] old_ent;
    logic             trig_after, evt_d;

    // Bus strobes.
    always_comb begin
        sel_wr = bus_en && bus_we && (bus_addr == SEL_ADDR);
        win_wr = bus_en && bus_we && (bus_addr == WIN_ADDR);
        rd_req = bus_en && !bus_we;
        ent_wr = win_wr && (kind == SK_ENT);
    end

    // Select register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 8'h00;
        else if (sel_wr)
            sel_q <= bus_wdata[7:0];
    end

    // ID field load; only the ID select is writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= 4'h0;
        else if (win_wr && kind == SK_ID)
            id_q <= bus_wdata[27:24];
    end

    irq_route_decode #(.PINS(PINS)) u_dec (
        .sel     (sel_q),
        .kind    (kind),
        .idx     (idx),
        .hi_half (hi_half)
    );

    // One storage slice per pin, each with its field outputs.
    for (genvar i = 0; i < PINS; i++) begin : g_ent
        logic hit;
        assign hit = ent_wr && (idx == IDXW'(i));

        irq_route_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !hi_half),
            .wr_hi    (hit && hi_half),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[i]),
            .rirr_clr (rirr_clr[i]),
            .ent_q    (tbl[i])
        );

        assign ent_vector[i*8 +: 8] = tbl[i][F_VEC_LO +: 8];
        assign ent_dlv[i*3 +: 3]    = tbl[i][F_DLV_LO +: 3];
        assign ent_dmode[i]         = tbl[i][F_DMODE];
        assign ent_rirr[i]          = tbl[i][F_RIRR];
        assign ent_trig[i]          = tbl[i][F_TRIG];
        assign ent_mask[i]          = tbl[i][F_MASK];
        assign ent_dest[i*8 +: 8]   = tbl[i][F_DEST_LO +: 8];
    end

    irq_route_rdmux #(.PINS(PINS), .VERSION(VERSION)) u_rd (
        .kind     (kind),
        .idx      (idx),
        .hi_half  (hi_half),
        .id_q     (id_q),
        .tbl      (tbl),
        .win_word (win_word)
    );

    // Read result register, loaded only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 32'h0;
        else if (rd_req) begin
            if (bus_addr == SEL_ADDR)
                bus_rdata <= {24'h0, sel_q};
            else if (bus_addr == WIN_ADDR)
                bus_rdata <= win_word;
            else
                bus_rdata <= 32'h0;
        end
    end

    // Event condition, judged from the entry before and the data written.
    always_comb begin
        old_ent    = tbl[idx];
        trig_after = hi_half ? old_ent[F_TRIG] : bus_wdata[F_TRIG];
        evt_d      = ent_wr &&
                     ((!hi_half && (bus_wdata[F_MASK] != old_ent[F_MASK])) ||
                      (trig_after && pend_in[idx]));
    end

    // Event pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_index <= '0;
        end else begin
            evt_valid <= evt_d;
            if (evt_d)
                evt_index <= idx;
        end
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(bus_wdata[7:0]))); // R1

    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && sel_q == SEL_ID) |=> $stable(id_q)); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R12

    AST_EVT_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(win_wr)); // R11

    AST_EVT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ({{(32-IDXW){1'b0}}, evt_index} < PINS)); // R11

    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && kind == SK_BAD) |=> !evt_valid); // R6

endmodule

// File: tb/sim_irq_route_regs.sv
`timescale 1ns/1ps
// Directed bench for irq_route_regs: one task per scenario, each self-checking.
module sim_irq_route_regs;
    localparam int PINS = 24;
    localparam int IDXW = $clog2(PINS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]        bus_addr = 8'h0;
    logic [31:0]       bus_wdata = 32'h0;
    logic [31:0]       bus_rdata;
    logic [PINS-1:0]   pend_in = '0, rirr_set = '0, rirr_clr = '0;
    logic [PINS*8-1:0] ent_vector, ent_dest;
    logic [PINS*3-1:0] ent_dlv;
    logic [PINS-1:0]   ent_dmode, ent_rirr, ent_trig, ent_mask;
    logic              evt_valid;
    logic [IDXW-1:0]   evt_index;

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;
    logic       last_ev;
    logic [4:0] last_ix;

    always #2.5 clk = ~clk;

    irq_route_regs #(.PINS(PINS)) u0 (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        last_ev = evt_valid; last_ix = evt_index;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic win_rd(logic [7:0] s, output logic [31:0] d);
        wr(8'h00, {24'h0, s});
        rd(8'h10, d);
    endtask

    task automatic win_wr(logic [7:0] s, logic [31:0] d);
        wr(8'h00, {24'h0, s});
        wr(8'h10, d);
    endtask

    task automatic pulse(logic [PINS-1:0] s, logic [PINS-1:0] c);
        @(negedge clk);
        rirr_set = s; rirr_clr = c;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R8 mask all set", ent_mask, {PINS{1'b1}});
        chk("R8 vectors zero", ent_vector, '0);
        chk("R8 dest zero", ent_dest, '0);
        chk("R11 no event at reset", evt_valid, 0);
        rd(8'h00, d); chk("R8 select zero", d, 0);
        rd(8'h10, d); chk("R3 version at reset select", d, 32'h0017_0011);
        wr(8'h00, 32'h1); rd(8'h10, d); chk("R8 id zero", d, 0);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(8'h00, 32'h0000_00A5); rd(8'h00, d); chk("R1 select readback", d, 32'hA5);
        wr(8'h00, 32'h1234_56C3); rd(8'h00, d); chk("R1 select 8 bits", d, 32'hC3);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R2 other offset reads 0", d, 0);
        rd(8'h00, d); chk("R2 select untouched", d, 32'hC3);
        rd(8'h14, d); chk("R2 offset 0x14 reads 0", d, 0);
    endtask

    task automatic t_version();
        logic [31:0] d;
        win_rd(8'h00, d); chk("R3 version word", d, 32'h0017_0011);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 version write ignored", d, 32'h0017_0011);
    endtask

    task automatic t_id();
        logic [31:0] d;
        win_wr(8'h01, 32'h05FF_FFFF); rd(8'h10, d); chk("R4 id readback", d, 32'h0500_0000);
        win_rd(8'h02, d); chk("R4 arb reads id", d, 32'h0500_0000);
        wr(8'h10, 32'h0A00_0000); win_rd(8'h01, d); chk("R4 arb write ignored", d, 32'h0500_0000);
    endtask

    task automatic t_entries();
        logic [31:0] d;
        win_wr(8'h16, 32'h0000_4D31);
        rd(8'h10, d); chk("R7 low write clears remote bit", d, 32'h0000_0D31);
        chk("R9 vector field", ent_vector[3*8 +: 8], 8'h31);
        chk("R9 delivery field", ent_dlv[3*3 +: 3], 3'd5);
        chk("R9 dest mode field", ent_dmode[3], 1);
        chk("R9 mask field", ent_mask[3], 0);
        chk("R9 remote field", ent_rirr[3], 0);
        win_wr(8'h17, 32'hC700_0000);
        chk("R9 dest field", ent_dest[3*8 +: 8], 8'hC7);
        rd(8'h10, d); chk("R5 high half readback", d, 32'hC700_0000);
        win_rd(8'h16, d); chk("R5 low half kept", d, 32'h0000_0D31);
        chk("R5 neighbour entry untouched", ent_mask[2] & ent_mask[4], 1);
        win_wr(8'h3E, 32'h0001_0077);
        rd(8'h10, d); chk("R5 last entry low", d, 32'h0001_0077);
        win_rd(8'h3F, d); chk("R5 last entry high", d, 0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        win_rd(8'h40, d); chk("R6 index PINS reads ones", d, 32'hFFFF_FFFF);
        win_rd(8'h41, d); chk("R6 index PINS high reads ones", d, 32'hFFFF_FFFF);
        win_rd(8'h05, d); chk("R6 gap select reads ones", d, 32'hFFFF_FFFF);
        win_wr(8'h40, 32'h0);
        chk("R6 discarded write no event", last_ev, 0);
        rd(8'h10, d); chk("R6 discarded write keeps ones", d, 32'hFFFF_FFFF);
        win_rd(8'h3E, d); chk("R6 last entry unchanged", d, 32'h0001_0077);
        chk("R6 mask ports unchanged", ent_mask, {PINS{1'b1}} & ~(PINS'(1) << 3));
    endtask

    task automatic t_remote();
        logic [31:0] d;
        pulse(PINS'(1) << 3, '0);
        chk("R10 set pulse", ent_rirr[3], 1);
        win_rd(8'h16, d); chk("R10 remote bit visible on bus", d, 32'h0000_4D31);
        win_wr(8'h17, 32'hC700_0000);
        chk("R7 high write keeps remote bit", ent_rirr[3], 1);
        win_wr(8'h16, 32'h0000_4D31);
        chk("R7 low write clears remote bit", ent_rirr[3], 0);
        pulse(PINS'(1) << 3, '0);
        pulse(PINS'(1) << 3, PINS'(1) << 3);
        chk("R10 clear wins over set", ent_rirr[3], 0);
        pulse(PINS'(1) << 3, '0);
        pulse('0, PINS'(1) << 3);
        chk("R10 clear pulse", ent_rirr[3], 0);
    endtask

    task automatic t_event();
        win_wr(8'h1A, 32'h0000_0040);
        chk("R11 mask change event", last_ev, 1);
        chk("R11 event index", last_ix, 5'd5);
        @(negedge clk); chk("R11 event one cycle", evt_valid, 0);
        win_wr(8'h1A, 32'h0000_0041);
        chk("R11 no change no event", last_ev, 0);
        pend_in[5] = 1'b1;
        win_wr(8'h1A, 32'h0000_8041);
        chk("R11 level pending event", last_ev, 1);
        win_wr(8'h1B, 32'h1100_0000);
        chk("R11 high write level pending event", last_ev, 1);
        chk("R11 high write index", last_ix, 5'd5);
        pend_in[5] = 1'b0;
        win_wr(8'h1B, 32'h2200_0000);
        chk("R11 no pending no event", last_ev, 0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        win_rd(8'h00, d); chk("R12 read captured", d, 32'h0017_0011);
        wr(8'h00, 32'h16);
        @(negedge clk); chk("R12 rdata held without read", bus_rdata, 32'h0017_0011);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_other();
        t_version();
        t_id();
        t_entries();
        t_range();
        t_remote();
        t_event();
        t_latency();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule